// File: doc/BRIEF.md
# PCI DMA Window Address Translator

This block sits between the inbound side of a PCI host bridge and system memory. Each accepted DMA request carries a 64-bit bus address and a flag marking a dual-address cycle. The block reports one of three outcomes: a claim with a 35-bit system address, a no-claim, or a page-table error. Four programmable windows cover the 32-bit bus space, and each one maps either directly onto memory or through a page table of 64-bit entries. A fixed high window serves dual-address cycles: when it is enabled, bus addresses above 1 TB go straight to memory.

For table-mapped windows, a small fully associative cache holds whole groups of four neighbouring page-table entries. On a cache miss the block issues one memory read for the whole 32-byte group and stalls new requests until the read returns. It then installs the group and answers the stalled request. A write-only register port programs the windows, switches the high window on or off, and flushes the cache all at once.

Top module: `pci_dma_xlate`

## Requirements
- R1: A dual-address request with the high-window enable set (control register, address 0xC, data bit 0) and address bits 63:40 equal to 0x000001 is claimed, and the system address is its bits 34:0 unchanged.
- R2: Bits 39:35 of a dual-address request have no effect on the high-window decision or on the system address.
- R3: A dual-address request is refused when the high window is disabled or when bits 63:40 differ from 0x000001. A single-address request with any of bits 63:32 set is also refused. Dual-address requests never use the four windows.
- R4: Window i is programmed at register address 4·k+i, where k=0 is the base register (bit 0 enable, bit 1 table mode, bits 31:20 base), k=1 is the mask (bits 31:20, a set bit lies inside the window), and k=2 is the translated base (bits 34:10). A single-address request hits an enabled window when its bits 31:20 equal the base on every bit the mask leaves clear.
- R5: A direct window returns the translated base OR the request address bits selected by the mask together with bits 19:0.
- R6: When several windows hit, the lowest-numbered one serves the request.
- R7: A request that hits no window is refused. A window whose enable bit is clear never hits, and this is the state out of reset.
- R8: A table window reads the entry at translated base (bits 9:0 ignored) plus 8 × (in-window offset >> 13). On a cache miss, one read is raised at that address with bits 4:0 cleared. The read is held steady until the response, and the four entries of the response sit in data bits 64j+63:64j for j = 0..3.
- R9: After a fill, requests to any of the four pages of that group are served without a memory read, one cycle after acceptance.
- R10: A page-table entry holds its valid flag in bit 0 and its page frame in bits 22:1. A valid entry gives the system address {frame, request bits 12:0}. An invalid entry raises the error outcome with a zero address.
- R11: Any write to register address 0xD empties the cache. A group whose read is still outstanding during such a write is used for that one response but is not installed.
- R12: Fills take cache slots in round-robin order starting from slot 0, and the order restarts at slot 0 after a flush. A full cache evicts the slot that was filled earliest.
- R13: Exactly one of hit, no-claim or error accompanies each response. Non-miss responses appear the cycle after acceptance. Miss responses appear the cycle after the memory response. Ready stays low while a read is outstanding.
- R14: After reset there is no response, ready is high, no memory read is raised and the high window is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | DMA request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_addr | input | 64 | PCI bus address |
| req_dac | input | 1 | Request is a dual-address cycle |
| rsp_valid | output | 1 | Translation result present |
| rsp_hit | output | 1 | Address claimed, rsp_addr valid |
| rsp_noclaim | output | 1 | No window claimed the address |
| rsp_err | output | 1 | Page-table entry was invalid |
| rsp_addr | output | 35 | System address |
| mem_rd_req | output | 1 | Page-table group read request |
| mem_rd_addr | output | 35 | Byte address of the 32-byte group |
| mem_rd_rsp_valid | input | 1 | Read data present |
| mem_rd_data | input | 256 | Four page-table entries |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 35 | Register write data |

## Verification
The bench builds the block with all four windows and only two cache slots. With two slots, a third distinct group already forces an eviction, so the round-robin order and its reset by a flush can be seen in a few requests. The four windows are placed so that a 32 MB direct window at zero overlaps an 8 MB table window, which exercises priority. Disabling the lower window then hands the same address to the upper one. A flush issued while a fill is in flight shows whether the late group is dropped.

// File: rtl/dxl_pkg.sv
package dxl_pkg;
  localparam int SA_W    = 35;             // system address width
  localparam int WA_W    = 32;             // window address space width
  localparam int PG_W    = 13;             // 8 KB page offset
  localparam int PFN_W   = SA_W - PG_W;    // page frame width
  localparam int PTE_W   = 64;
  localparam int GRP_N   = 4;              // entries per cache line
  localparam int GRP_LW  = $clog2(GRP_N);
  localparam int GA_LO   = 3 + GRP_LW;     // group byte-offset bits
  localparam int GA_W    = SA_W - GA_LO;   // group tag width
  localparam int TBA_LO  = 10;
  localparam int TBA_W   = SA_W - TBA_LO;
  localparam int WG_LO   = 20;             // 1 MB window granule
  localparam int WG_W    = WA_W - WG_LO;
  localparam logic [23:0] HIWIN_TAG = 24'h000001;

  typedef struct packed {
    logic             v;
    logic [PFN_W-1:0] pfn;
  } pte_t;

  typedef logic [GRP_N-1:0][PFN_W:0] grp_flat_t;

  function automatic logic [WA_W-1:0] off_mask(input logic [WG_W-1:0] m);
    return {m, {WG_LO{1'b1}}};
  endfunction

  function automatic logic win_match(input logic [WA_W-1:0] a,
                                     input logic [WG_W-1:0] base,
                                     input logic [WG_W-1:0] m);
    return (((a[WA_W-1:WG_LO] ^ base) & ~m) == '0);
  endfunction

  function automatic logic [SA_W-1:0] direct_xlate(input logic [WA_W-1:0] a,
                                                   input logic [WG_W-1:0] m,
                                                   input logic [TBA_W-1:0] tba);
    return {tba, {TBA_LO{1'b0}}} | {{(SA_W-WA_W){1'b0}}, a & off_mask(m)};
  endfunction

  function automatic logic [SA_W-1:0] pte_addr(input logic [WA_W-1:0] a,
                                               input logic [WG_W-1:0] m,
                                               input logic [TBA_W-1:0] tba);
    logic [SA_W-1:0] idx;
    idx = SA_W'((a & off_mask(m)) >> PG_W);
    return {tba, {TBA_LO{1'b0}}} + (idx << 3);
  endfunction

  function automatic pte_t pte_decode(input logic [PTE_W-1:0] w);
    pte_t p;
    p.v   = w[0];
    p.pfn = w[PFN_W:1];
    return p;
  endfunction

  function automatic logic [SA_W-1:0] sg_xlate(input pte_t p,
                                               input logic [PG_W-1:0] off);
    return {p.pfn, off};
  endfunction
endpackage

// File: rtl/dxl_win_sel.sv
module dxl_win_sel
  import dxl_pkg::*;
#(
  parameter int NWIN = 4,
  localparam int IW = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic [WA_W-1:0]            addr,
  input  logic                       chk,
  input  logic [NWIN-1:0]            en,
  input  logic [NWIN-1:0][WG_W-1:0]  base,
  input  logic [NWIN-1:0][WG_W-1:0]  mask,
  output logic [NWIN-1:0]            sel,
  output logic                       any,
  output logic [IW-1:0]              idx
);
  logic [NWIN-1:0] raw;

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    assign raw[i] = chk && en[i] && win_match(addr, base[i], mask[i]);
  end

  always_comb begin
    sel = '0;
    idx = '0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (raw[i]) begin
        sel    = '0;
        sel[i] = 1'b1;
        idx    = IW'(i);
      end
    end
  end

  assign any = |raw;

  // R6: at most one winner, and only from windows that actually hit
  always_comb begin
    a_r6_sel_onehot: assert ($onehot0(sel));
    a_r6_sel_in_raw: assert ((sel & ~raw) == '0);
  end
endmodule

// File: rtl/dxl_tlb.sv
module dxl_tlb
  import dxl_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [GA_W-1:0]       lk_tag,
  output logic                  lk_hit,
  output pte_t [GRP_N-1:0]      lk_grp,
  input  logic                  fill_en,
  input  logic [GA_W-1:0]       fill_tag,
  input  pte_t [GRP_N-1:0]      fill_grp,
  input  logic                  flush
);
  logic [DEPTH-1:0]           vld;
  logic [DEPTH-1:0][GA_W-1:0] tag;
  pte_t [DEPTH-1:0][GRP_N-1:0] dat;
  logic [DEPTH-1:0]           match;
  logic [PW-1:0]              ptr;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign match[i] = vld[i] && (tag[i] == lk_tag);
  end

  always_comb begin
    lk_grp = '0;
    for (int i = 0; i < DEPTH; i++)
      if (match[i]) lk_grp = lk_grp | dat[i];
  end
  assign lk_hit = |match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      ptr <= '0;
    end else if (flush) begin
      vld <= '0;
      ptr <= '0;
    end else if (fill_en) begin
      vld[ptr] <= 1'b1;
      ptr      <= (ptr == PW'(DEPTH - 1)) ? '0 : ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en && !flush) begin
      tag[ptr] <= fill_tag;
      dat[ptr] <= fill_grp;
    end
  end

  a_r11_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld == '0));
  a_r12_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));
  a_r12_fill_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !flush) |=> vld[$past(ptr)]);
endmodule

// File: rtl/pci_dma_xlate.sv
module pci_dma_xlate
  import dxl_pkg::*;
#(
  parameter int NWIN      = 4,   // at most 4: two register-address bits
  parameter int TLB_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [63:0]       req_addr,
  input  logic              req_dac,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_noclaim,
  output logic              rsp_err,
  output logic [34:0]       rsp_addr,
  output logic              mem_rd_req,
  output logic [34:0]       mem_rd_addr,
  input  logic              mem_rd_rsp_valid,
  input  logic [255:0]      mem_rd_data,
  input  logic              reg_wr,
  input  logic [3:0]        reg_addr,
  input  logic [34:0]       reg_wdata
);
  localparam int IW = (NWIN > 1) ? $clog2(NWIN) : 1;
  localparam logic [1:0] K_BASE = 2'd0, K_MASK = 2'd1, K_TBA = 2'd2, K_MISC = 2'd3;

  typedef enum logic {ST_IDLE, ST_FETCH} st_t;

  // ---------------- configuration registers ----------------
  logic [NWIN-1:0]             w_en, w_sg;
  logic [NWIN-1:0][WG_W-1:0]   w_base, w_mask;
  logic [NWIN-1:0][TBA_W-1:0]  w_tba;
  logic                        hiwin_en;
  logic                        tlb_inv;
  logic                        unused_wdata;

  assign unused_wdata = ^reg_wdata[9:2];

  for (genvar i = 0; i < NWIN; i++) begin : g_wreg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        w_en[i] <= 1'b0; w_sg[i] <= 1'b0;
        w_base[i] <= '0; w_mask[i] <= '0; w_tba[i] <= '0;
      end else if (reg_wr && reg_addr[1:0] == 2'(i)) begin
        case (reg_addr[3:2])
          K_BASE: begin
            w_en[i]   <= reg_wdata[0];
            w_sg[i]   <= reg_wdata[1];
            w_base[i] <= reg_wdata[WA_W-1:WG_LO];
          end
          K_MASK: w_mask[i] <= reg_wdata[WA_W-1:WG_LO];
          K_TBA:  w_tba[i]  <= reg_wdata[SA_W-1:TBA_LO];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) hiwin_en <= 1'b0;
    else if (reg_wr && reg_addr == {K_MISC, 2'd0}) hiwin_en <= reg_wdata[0];
  end
  assign tlb_inv = reg_wr && (reg_addr == {K_MISC, 2'd1});

  // ---------------- decode ----------------
  st_t              st;
  logic             drop;
  logic [PG_W-1:0]  pend_off;
  logic [GRP_LW-1:0] pend_lane;

  logic             hiwin_hit, sac_ok, win_any;
  logic [NWIN-1:0]  win_sel;
  logic [IW-1:0]    win_idx;
  logic [SA_W-1:0]  dir_addr, pa;
  logic [GA_W-1:0]  grp_tag;
  logic [GRP_LW-1:0] lane;
  logic             lk_hit;
  pte_t [GRP_N-1:0] lk_grp, fill_grp;
  pte_t             lk_pte, fill_pte;

  assign req_ready = (st == ST_IDLE);
  assign hiwin_hit = req_dac && hiwin_en && (req_addr[63:40] == HIWIN_TAG);
  assign sac_ok    = !req_dac && (req_addr[63:32] == '0);

  dxl_win_sel #(.NWIN(NWIN)) u_sel (
    .addr (req_addr[WA_W-1:0]),
    .chk  (sac_ok),
    .en   (w_en),
    .base (w_base),
    .mask (w_mask),
    .sel  (win_sel),
    .any  (win_any),
    .idx  (win_idx)
  );

  assign dir_addr = direct_xlate(req_addr[WA_W-1:0], w_mask[win_idx], w_tba[win_idx]);
  assign pa       = pte_addr(req_addr[WA_W-1:0], w_mask[win_idx], w_tba[win_idx]);
  assign grp_tag  = pa[SA_W-1:GA_LO];
  assign lane     = pa[GA_LO-1:3];
  assign lk_pte   = lk_grp[lane];

  for (genvar j = 0; j < GRP_N; j++) begin : g_lane
    assign fill_grp[j] = pte_decode(mem_rd_data[j*PTE_W +: PTE_W]);
  end
  assign fill_pte = fill_grp[pend_lane];

  // named events, used by the datapath and by the assertions
  logic ev_accept, ev_hiwin, ev_noclaim, ev_direct, ev_tlb_hit, ev_miss;
  logic ev_fill_rsp, ev_fill;
  assign ev_accept   = req_valid && req_ready;
  assign ev_hiwin    = ev_accept && hiwin_hit;
  assign ev_noclaim  = ev_accept && !hiwin_hit && !win_any;
  assign ev_direct   = ev_accept && !hiwin_hit && win_any && !w_sg[win_idx];
  assign ev_tlb_hit  = ev_accept && !hiwin_hit && win_any && w_sg[win_idx] && lk_hit;
  assign ev_miss     = ev_accept && !hiwin_hit && win_any && w_sg[win_idx] && !lk_hit;
  assign ev_fill_rsp = (st == ST_FETCH) && mem_rd_rsp_valid;
  assign ev_fill     = ev_fill_rsp && !drop && !tlb_inv;

  dxl_tlb #(.DEPTH(TLB_DEPTH)) u_tlb (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_tag   (grp_tag),
    .lk_hit   (lk_hit),
    .lk_grp   (lk_grp),
    .fill_en  (ev_fill),
    .fill_tag (mem_rd_addr[SA_W-1:GA_LO]),
    .fill_grp (fill_grp),
    .flush    (tlb_inv)
  );

  // ---------------- response and fetch control ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      drop        <= 1'b0;
      pend_off    <= '0;
      pend_lane   <= '0;
      mem_rd_req  <= 1'b0;
      mem_rd_addr <= '0;
      rsp_valid   <= 1'b0;
      rsp_hit     <= 1'b0;
      rsp_noclaim <= 1'b0;
      rsp_err     <= 1'b0;
      rsp_addr    <= '0;
    end else begin
      rsp_valid   <= 1'b0;
      rsp_hit     <= 1'b0;
      rsp_noclaim <= 1'b0;
      rsp_err     <= 1'b0;
      rsp_addr    <= '0;
      if (ev_fill_rsp) begin
        rsp_valid <= 1'b1;
        rsp_hit   <= fill_pte.v;
        rsp_err   <= !fill_pte.v;
        rsp_addr  <= fill_pte.v ? sg_xlate(fill_pte, pend_off) : '0;
      end else if (ev_hiwin) begin
        rsp_valid <= 1'b1;
        rsp_hit   <= 1'b1;
        rsp_addr  <= req_addr[SA_W-1:0];
      end else if (ev_noclaim) begin
        rsp_valid   <= 1'b1;
        rsp_noclaim <= 1'b1;
      end else if (ev_direct) begin
        rsp_valid <= 1'b1;
        rsp_hit   <= 1'b1;
        rsp_addr  <= dir_addr;
      end else if (ev_tlb_hit) begin
        rsp_valid <= 1'b1;
        rsp_hit   <= lk_pte.v;
        rsp_err   <= !lk_pte.v;
        rsp_addr  <= lk_pte.v ? sg_xlate(lk_pte, req_addr[PG_W-1:0]) : '0;
      end

      if (ev_miss) begin
        st          <= ST_FETCH;
        drop        <= 1'b0;
        mem_rd_req  <= 1'b1;
        mem_rd_addr <= {grp_tag, {GA_LO{1'b0}}};
        pend_off    <= req_addr[PG_W-1:0];
        pend_lane   <= lane;
      end else if (st == ST_FETCH) begin
        if (tlb_inv) drop <= 1'b1;
        if (mem_rd_rsp_valid) begin
          st         <= ST_IDLE;
          mem_rd_req <= 1'b0;
        end
      end
    end
  end

  // ---------------- assertions ----------------
  a_r13_stall_during_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> !req_ready);
  a_r8_read_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_rd_rsp_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));
  a_r8_group_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> (mem_rd_addr[GA_LO-1:0] == '0));
  a_r1_hiwin_pass: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hiwin |=> (rsp_valid && rsp_hit && rsp_addr == $past(req_addr[SA_W-1:0])));
  a_r3_high_sac_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && !req_dac && req_addr[63:32] != '0) |=> (rsp_valid && rsp_noclaim));
  a_r13_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones({rsp_hit, rsp_noclaim, rsp_err}) == 1));
  a_r13_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !(rsp_hit || rsp_noclaim || rsp_err));
  a_r13_miss_answers_late: assert property (@(posedge clk) disable iff (!rst_n)
    ev_miss |=> !rsp_valid);
endmodule

// File: tb/pci_dma_xlate_tb.sv
module pci_dma_xlate_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [63:0]  req_addr = '0;
  logic         req_dac = 1'b0;
  logic         rsp_valid, rsp_hit, rsp_noclaim, rsp_err;
  logic [34:0]  rsp_addr;
  logic         mem_rd_req;
  logic [34:0]  mem_rd_addr;
  logic         mem_rd_rsp_valid = 1'b0;
  logic [255:0] mem_rd_data = '0;
  logic         reg_wr = 1'b0;
  logic [3:0]   reg_addr = '0;
  logic [34:0]  reg_wdata = '0;

  always #2 clk = ~clk;  // 250 MHz

  pci_dma_xlate #(.NWIN(4), .TLB_DEPTH(2)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_dac(req_dac),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_noclaim(rsp_noclaim), .rsp_err(rsp_err),
    .rsp_addr(rsp_addr),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_rsp_valid(mem_rd_rsp_valid), .mem_rd_data(mem_rd_data),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata)
  );

  int n_chk = 0, n_bad = 0;
  int n_reads = 0, exp_reads = 0;
  longint last_rd = 0;

  typedef struct packed { logic hit; logic nc; logic err; logic [34:0] a; } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];

  // bench window model
  longint m_start[4], m_size[4], m_tba[4];
  bit     m_en[4], m_sg[4];
  bit     m_hiwin = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  function automatic logic [63:0] model_pte(input longint pa);
    logic [21:0] pfn;
    logic        v;
    pfn = 22'(pa >> 3) ^ 22'h2A5A5;
    v   = (((pa >> 3) & 31) != 7);
    return {41'b0, pfn, v};
  endfunction

  function automatic exp_t predict(input logic [63:0] a, input bit dac);
    exp_t e;
    e = '0;
    if (dac) begin
      if (m_hiwin && a[63:40] == 24'h1) begin e.hit = 1; e.a = a[34:0]; end
      else e.nc = 1;
      return e;
    end
    if (a[63:32] != 0) begin e.nc = 1; return e; end
    for (int i = 0; i < 4; i++) begin
      longint ad;
      ad = longint'(a[31:0]);
      if (m_en[i] && ad >= m_start[i] && ad < m_start[i] + m_size[i]) begin
        if (!m_sg[i]) begin
          e.hit = 1; e.a = 35'(m_tba[i] + (ad - m_start[i]));
        end else begin
          longint pa;
          logic [63:0] w;
          pa = m_tba[i] + ((ad - m_start[i]) / 8192) * 8;
          w  = model_pte(pa);
          if (!w[0]) e.err = 1;
          else begin e.hit = 1; e.a = {w[22:1], a[12:0]}; end
        end
        return e;
      end
    end
    e.nc = 1;
    return e;
  endfunction

  task automatic wr(input logic [3:0] ad, input logic [34:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = ad; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic cfg_win(input int i, input bit en, input bit sg, input longint start,
                         input longint size, input longint tba_raw);
    logic [11:0] mfield;
    mfield = 12'((size >> 20) - 1);
    wr(4'(i), {3'b0, start[31:20], 18'b0, sg, en});
    wr(4'(4 + i), {3'b0, mfield, 20'b0});
    wr(4'(8 + i), 35'(tba_raw));
    m_en[i] = en; m_sg[i] = sg; m_start[i] = start; m_size[i] = size;
    m_tba[i] = tba_raw & ~longint'(1023);   // R8: bits 9:0 ignored
  endtask

  // driver: push expectation, present the request for one accepted cycle
  task automatic send(input logic [63:0] a, input bit dac, input bit miss, input string req);
    exp_q.push_back(predict(a, dac));
    tag_q.push_back(req);
    if (miss) exp_reads++;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_addr = a; req_dac = dac;
    @(negedge clk);
    req_valid = 0;
    if (!miss) check(rsp_valid === 1'b1, "R13 next-cycle response", longint'(rsp_valid), 1);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rsp_valid) begin
        if (exp_q.size() == 0) begin
          check(0, "R13 unexpected response", 1, 0);
        end else begin
          exp_t  e, got;
          string r;
          e = exp_q.pop_front();
          r = tag_q.pop_front();
          got = {rsp_hit, rsp_noclaim, rsp_err, rsp_addr};
          check(got === e, r, longint'(got), longint'(e));
        end
      end
    end
  end

  // memory model: answers a group read two cycles after seeing it
  initial begin
    forever begin
      @(negedge clk);
      if (mem_rd_req) begin
        longint g;
        g = longint'(mem_rd_addr);
        n_reads++;
        last_rd = g;
        repeat (2) @(negedge clk);
        for (int j = 0; j < 4; j++) mem_rd_data[j*64 +: 64] = model_pte(g + 8 * j);
        mem_rd_rsp_valid = 1;
        @(negedge clk);
        mem_rd_rsp_valid = 0;
        check(rsp_valid === 1'b1, "R13 miss response after fill", longint'(rsp_valid), 1);
      end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R13 watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_en[i] = 0; m_sg[i] = 0; m_start[i] = 0; m_size[i] = 0; m_tba[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(rsp_valid === 1'b0, "R14 no response after reset", longint'(rsp_valid), 0);
    check(req_ready === 1'b1, "R14 ready after reset", longint'(req_ready), 1);
    check(mem_rd_req === 1'b0, "R14 no read after reset", longint'(mem_rd_req), 0);

    send(64'h0000_0000_8000_0000, 0, 0, "R7 windows disabled at reset");
    send(64'h0000_0100_0000_1234, 1, 0, "R14 high window off at reset");

    cfg_win(0, 1, 1, 64'h0080_0000, 64'h0080_0000, 64'h1_2345_67FF);
    cfg_win(1, 1, 0, 64'h8000_0000, 64'h4000_0000, 64'h4_0000_0000);
    cfg_win(2, 1, 1, 64'hC000_0000, 64'h4000_0000, 64'h0_0010_0000);
    cfg_win(3, 1, 0, 64'h0000_0000, 64'h0200_0000, 64'h2_0000_0000);
    wr(4'hC, 35'd1); m_hiwin = 1;

    send(64'h0000_0100_0000_1234, 1, 0, "R1 high window pass-through");
    send(64'h0000_01F8_1234_5678, 1, 0, "R2 bits 39:35 ignored");
    send(64'h0000_0107_FFFF_FFF0, 1, 0, "R1 top of high window");
    send(64'h0000_0300_0000_0000, 1, 0, "R3 wrong high tag");
    send(64'h0000_0100_0000_0000, 0, 0, "R3 single-address above 4G");
    send(64'h0000_0000_8123_4568, 1, 0, "R3 dual-address never uses windows");
    send(64'h0000_0000_8123_4568, 0, 0, "R5 direct window");
    send(64'h0000_0000_BFFF_FFFF, 0, 0, "R5 direct window top");
    send(64'h0000_0000_0100_0010, 0, 0, "R4 lower direct window");
    send(64'h0000_0000_0200_0000, 0, 0, "R7 gap between windows");
    drain();

    send(64'h0000_0000_0080_2000, 0, 1, "R8 first table access");
    drain();
    check(last_rd == 64'h1_2345_6400, "R8 group read address", last_rd, 64'h1_2345_6400);
    send(64'h0000_0000_0080_6ABC, 0, 0, "R9 same group hit");
    drain();
    check(n_reads == exp_reads, "R9 no read on hit", n_reads, exp_reads);
    send(64'h0000_0000_0080_8000, 0, 1, "R8 second group");
    send(64'h0000_0000_C000_0000, 0, 1, "R8 upper table window");
    drain();
    check(last_rd == 64'h0010_0000, "R8 upper group address", last_rd, 64'h0010_0000);
    send(64'h0000_0000_0080_8010, 0, 0, "R12 newer slot kept");
    send(64'h0000_0000_0080_0000, 0, 1, "R12 oldest slot evicted");
    send(64'h0000_0000_0080_E000, 0, 1, "R10 invalid entry error");
    send(64'h0000_0000_0090_0000, 0, 1, "R6 lower window wins overlap");
    drain();
    check(n_reads == exp_reads, "R12 read count", n_reads, exp_reads);

    wr(4'hD, 35'd0);
    send(64'h0000_0000_0080_E008, 0, 1, "R11 flush forces refetch");
    drain();
    check(n_reads == exp_reads, "R11 read after flush", n_reads, exp_reads);

    fork
      send(64'h0000_0000_C000_4000, 0, 1, "R11 fill during flush");
      begin
        wait (mem_rd_req === 1'b1);
        @(negedge clk);
        check(req_ready === 1'b0, "R13 stall while fetching", longint'(req_ready), 0);
        wr(4'hD, 35'd0);
      end
    join
    drain();
    send(64'h0000_0000_C000_4000, 0, 1, "R11 dropped fill not installed");
    drain();
    check(n_reads == exp_reads, "R11 dropped fill refetched", n_reads, exp_reads);

    wr(4'h0, 35'd0); m_en[0] = 0;
    send(64'h0000_0000_0090_0000, 0, 0, "R6 next window after disable");
    wr(4'hC, 35'd0); m_hiwin = 0;
    send(64'h0000_0100_0000_1234, 1, 0, "R3 high window disabled");
    drain();
    check(exp_q.size() == 0, "R13 all responses seen", exp_q.size(), 0);
    summary();
  end
endmodule